// File: doc/BRIEF.md
# Programmable YUV-to-RGB Color Converter

This block turns a stream of full-resolution YUV pixels into packed RGB pixels. Each accepted input carries one 8-bit luma sample and two 8-bit chroma samples. Five unsigned fixed-point coefficients scale the samples. Each coefficient has 10 fractional bits, so a value of 1024 means 1.0. The three channel sums are rounded, clamped to 0..255 and packed into a 24-bit output word in one of three layouts. The pipeline has three register stages and a single valid/ready handshake on each side. When the output is stalled, every stage holds its contents.

Software uses a small register port to program the block. The port holds a run bit with a self-clearing soft-clear, the output layout and luma range mode, the coefficient set, and a pixel target. A sticky end flag rises when the target-th pixel leaves the output. A typical flow is to program the coefficients and layout, load the pixel count, set the run bit, stream the frame, then wait for the end flag and clear it.

Top module: `yuv_rgb_conv`

## Requirements
- R1: For each channel the result is R = C0·Y' + C1·V', G = C0·Y' − C2·U' − C3·V', B = C0·Y' + C4·U', with U' = U−128 and V' = V−128. Each sum has 512 added, is shifted right arithmetically by 10 bits, and is clamped to 0..255.
- R2: The range bit is format register bit 4. When it is 0 (video range), 16 is subtracted from Y to give Y'. When it is 1 (full range), Y' = Y.
- R3: Registers 4..8 hold C0..C4 as 12-bit unsigned values. After reset they read 0x4A8, 0x662, 0x191, 0x341 and 0x811, and any written value is used by the next pixel computed.
- R4: Output layout field bits 17:16 of the format register (register 2). Codes 2 and 3 give out_pix = {R, G, B}, with R in bits 23:16.
- R5: Layout code 1 (the reset value) gives out_pix[15:0] = {R[7:3], G[7:2], B[7:3]} with bits 23:16 zero.
- R6: Layout code 0 gives out_pix[14:0] = {R[7:3], G[7:3], B[7:3]} with bits 23:15 zero.
- R7: A pixel accepted at a rising edge with out_ready high appears on out_valid/out_pix after the second edge that follows it, and not earlier.
- R8: While out_valid is high and out_ready is low, out_pix and out_valid hold and in_ready is low. Pixels then leave in the order they were accepted.
- R9: The run bit is control register (register 0) bit 0 and is 0 after reset. While it is 0, in_ready is low and nothing is accepted.
- R10: Register writes obey the byte strobes reg_be. The input format field (format bits 2:0, reset value 6) and the layout field change only when their own byte is strobed.
- R11: Register 3 holds the pixel target. The end flag (status register 1 bit 0, also on end_flag) sets after the output handshake of the target-th pixel, stays set, and clears on a write of 1 to status bit 0. A target of 0 never sets it.
- R12: Writing 1 to control bit 1 empties the pipeline and clears the pixel counter and the end flag. It leaves the coefficients and the format unchanged.
- R13: reg_rdata shows the register selected by reg_addr one rising edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high with in_valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 24 | Packed RGB pixel |
| end_flag | output | 1 | Sticky end-of-count flag |

## Verification
Each converted pixel is due exactly two edges after the edge that accepts it. The bench checks that out_valid is still low after the first of those edges, then compares the pixel after the second. Register reads are sampled one edge after the address is presented. The end flag is sampled one edge after the cycle in which the final pixel is presented with out_ready high. Under backpressure the bench fills all three stages and holds the output for several cycles. It then releases the stall and expects one pixel per edge, in the order the pixels were accepted.

// File: rtl/yrc_pkg.sv
package yrc_pkg;

  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_FMT   = 2;
  localparam int REG_CNT   = 3;
  localparam int REG_COEF0 = 4;
  localparam int NUM_COEF  = 5;

  typedef enum logic [1:0] {
    PK_555  = 2'd0,
    PK_565  = 2'd1,
    PK_888  = 2'd2,
    PK_888B = 2'd3
  } pack_e;

  // video-range coefficient set, scaled by 1024
  function automatic logic [31:0] coef_default(input int idx);
    case (idx)
      0:       return 32'h4A8;
      1:       return 32'h662;
      2:       return 32'h191;
      3:       return 32'h341;
      default: return 32'h811;
    endcase
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return (cur & ~m) | (nxt & m);
  endfunction

endpackage

// File: rtl/yrc_regs.sv
module yrc_regs
  import yrc_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  input  logic [3:0]                  be,
  input  logic                        out_fire,
  output logic [31:0]                 rd_data,
  output logic                        run_en,
  output logic                        soft_clr,
  output logic                        full_range,
  output pack_e                       out_fmt,
  output logic [NUM_COEF-1:0][COEF_W-1:0] coef,
  output logic                        end_flag
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(REG_FMT);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);

  logic [2:0]       in_fmt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] done_cnt;
  logic [31:0]      fmt_word, cnt_word;
  logic [31:0]      m_fmt, m_cnt;
  logic [31:0]      m_coef [NUM_COEF];
  logic             wr_ctrl, wr_stat, wr_fmt, wr_cnt, hit;

  always_comb begin
    fmt_word = {14'b0, out_fmt, 11'b0, full_range, 1'b0, in_fmt};
    cnt_word = 32'(target);
    m_fmt    = byte_merge(fmt_word, wdata, be);
    m_cnt    = byte_merge(cnt_word, wdata, be);
    for (int i = 0; i < NUM_COEF; i++)
      m_coef[i] = byte_merge(32'(coef[i]), wdata, be);
    wr_ctrl  = we && (addr == A_CTRL);
    wr_stat  = we && (addr == A_STAT);
    wr_fmt   = we && (addr == A_FMT);
    wr_cnt   = we && (addr == A_CNT);
    soft_clr = wr_ctrl && be[0] && wdata[1];
    hit      = out_fire && (target != '0) && (done_cnt == target - 1'b1)
               && !soft_clr && !wr_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en     <= 1'b0;
      in_fmt     <= 3'd6;
      full_range <= 1'b0;
      out_fmt    <= PK_565;
      target     <= '0;
      done_cnt   <= '0;
      end_flag   <= 1'b0;
      for (int i = 0; i < NUM_COEF; i++)
        coef[i] <= COEF_W'(coef_default(i));
    end else begin
      if (wr_ctrl && be[0]) run_en <= wdata[0];
      if (wr_fmt) begin
        in_fmt     <= m_fmt[2:0];
        full_range <= m_fmt[4];
        out_fmt    <= pack_e'(m_fmt[17:16]);
      end
      if (wr_cnt) target <= m_cnt[CNT_W-1:0];
      for (int i = 0; i < NUM_COEF; i++)
        if (we && (addr == ADDR_W'(REG_COEF0 + i)))
          coef[i] <= m_coef[i][COEF_W-1:0];

      if (soft_clr || wr_cnt)      done_cnt <= '0;
      else if (hit)                done_cnt <= '0;
      else if (out_fire)           done_cnt <= done_cnt + 1'b1;

      if (soft_clr)                            end_flag <= 1'b0;
      else if (hit)                            end_flag <= 1'b1;
      else if (wr_stat && be[0] && wdata[0])   end_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        A_CTRL:  rd_data <= {31'b0, run_en};
        A_STAT:  rd_data <= {31'b0, end_flag};
        A_FMT:   rd_data <= fmt_word;
        A_CNT:   rd_data <= cnt_word;
        default: begin
          rd_data <= '0;
          for (int i = 0; i < NUM_COEF; i++)
            if (addr == ADDR_W'(REG_COEF0 + i)) rd_data <= 32'(coef[i]);
        end
      endcase
    end
  end

endmodule

// File: rtl/yrc_core.sv
module yrc_core #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int ACC_W  = 24,
  parameter int NCOEF  = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          adv,
  input  logic                          in_take,
  input  logic [PIX_W-1:0]              y,
  input  logic [PIX_W-1:0]              u,
  input  logic [PIX_W-1:0]              v,
  input  logic                          full_range,
  input  logic [NCOEF-1:0][COEF_W-1:0]  coef,
  output logic                          s2_valid,
  output logic signed [ACC_W-1:0]       acc_r,
  output logic signed [ACC_W-1:0]       acc_g,
  output logic signed [ACC_W-1:0]       acc_b
);

  localparam int YW     = PIX_W + 2;
  localparam int CW     = PIX_W + 1;
  localparam int CBIAS  = 1 << (PIX_W - 1);
  localparam int LOFF   = 1 << (PIX_W - 4);

  // stage 1: offset removal
  logic                 s1_valid;
  logic signed [YW-1:0] ys;
  logic signed [CW-1:0] us, vs;
  logic signed [YW-1:0] y_adj;
  logic signed [CW-1:0] u_adj, v_adj;

  always_comb begin
    y_adj = $signed({2'b00, y}) - (full_range ? YW'(0) : YW'(LOFF));
    u_adj = $signed({1'b0, u}) - CW'(CBIAS);
    v_adj = $signed({1'b0, v}) - CW'(CBIAS);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) s1_valid <= 1'b0;
    else if (adv)   s1_valid <= in_take;
  end

  always_ff @(posedge clk) begin
    if (adv && in_take) begin
      ys <= y_adj;
      us <= u_adj;
      vs <= v_adj;
    end
  end

  // stage 2: products and sums
  logic signed [ACC_W-1:0] cx [NCOEF];
  logic signed [ACC_W-1:0] yx, ux, vx;
  logic signed [ACC_W-1:0] p_y, p_rv, p_gu, p_gv, p_bu;

  always_comb begin
    for (int i = 0; i < NCOEF; i++)
      cx[i] = {{(ACC_W-COEF_W){1'b0}}, coef[i]};
    yx   = {{(ACC_W-YW){ys[YW-1]}}, ys};
    ux   = {{(ACC_W-CW){us[CW-1]}}, us};
    vx   = {{(ACC_W-CW){vs[CW-1]}}, vs};
    p_y  = cx[0] * yx;
    p_rv = cx[1] * vx;
    p_gu = cx[2] * ux;
    p_gv = cx[3] * vx;
    p_bu = cx[4] * ux;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) s2_valid <= 1'b0;
    else if (adv)   s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && s1_valid) begin
      acc_r <= p_y + p_rv;
      acc_g <= p_y - p_gu - p_gv;
      acc_b <= p_y + p_bu;
    end
  end

endmodule

// File: rtl/yrc_pack.sv
module yrc_pack
  import yrc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  parameter int FRAC  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    adv,
  input  logic                    s2_valid,
  input  pack_e                   fmt,
  input  logic signed [ACC_W-1:0] acc_r,
  input  logic signed [ACC_W-1:0] acc_g,
  input  logic signed [ACC_W-1:0] acc_b,
  output logic                    out_valid,
  output logic [3*PIX_W-1:0]      out_pix
);

  localparam int OUT_W = 3 * PIX_W;
  localparam int HALF  = 1 << (FRAC - 1);

  function automatic logic [PIX_W-1:0] sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t, sh;
    t  = a + $signed(ACC_W'(HALF));
    sh = t >>> FRAC;
    if (t[ACC_W-1])                return '0;
    else if (|sh[ACC_W-1:PIX_W])   return '1;
    else                           return sh[PIX_W-1:0];
  endfunction

  logic [PIX_W-1:0] r8, g8, b8;
  logic [OUT_W-1:0] packed_pix;

  always_comb begin
    r8 = sat(acc_r);
    g8 = sat(acc_g);
    b8 = sat(acc_b);
    case (fmt)
      PK_555:  packed_pix = {{(OUT_W-15){1'b0}},
                             r8[PIX_W-1 -: 5], g8[PIX_W-1 -: 5], b8[PIX_W-1 -: 5]};
      PK_565:  packed_pix = {{(OUT_W-16){1'b0}},
                             r8[PIX_W-1 -: 5], g8[PIX_W-1 -: 6], b8[PIX_W-1 -: 5]};
      default: packed_pix = {r8, g8, b8};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) out_valid <= 1'b0;
    else if (adv)   out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (rst)                  out_pix <= '0;
    else if (adv && s2_valid) out_pix <= packed_pix;
  end

endmodule

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv
  import yrc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int FRAC   = 10,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [3:0]         reg_be,
  output logic [31:0]        reg_rdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_y,
  input  logic [PIX_W-1:0]   in_u,
  input  logic [PIX_W-1:0]   in_v,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [3*PIX_W-1:0] out_pix,
  output logic               end_flag
);

  localparam int ACC_W = COEF_W + PIX_W + 4;

  logic                             ctl_en, soft_clr, full_range, adv, in_take, out_fire;
  logic                             s2_vld;
  pack_e                            out_fmt;
  logic [NUM_COEF-1:0][COEF_W-1:0]  coef;
  logic signed [ACC_W-1:0]          acc_r, acc_g, acc_b;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = ctl_en && adv;
  assign in_take  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  yrc_regs #(.COEF_W(COEF_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .be(reg_be), .out_fire(out_fire), .rd_data(reg_rdata), .run_en(ctl_en),
    .soft_clr(soft_clr), .full_range(full_range), .out_fmt(out_fmt),
    .coef(coef), .end_flag(end_flag)
  );

  yrc_core #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .NCOEF(NUM_COEF)) u_core (
    .clk(clk), .rst(rst), .clr(soft_clr), .adv(adv), .in_take(in_take),
    .y(in_y), .u(in_u), .v(in_v), .full_range(full_range), .coef(coef),
    .s2_valid(s2_vld), .acc_r(acc_r), .acc_g(acc_g), .acc_b(acc_b)
  );

  yrc_pack #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_pack (
    .clk(clk), .rst(rst), .clr(soft_clr), .adv(adv), .s2_valid(s2_vld),
    .fmt(out_fmt), .acc_r(acc_r), .acc_g(acc_g), .acc_b(acc_b),
    .out_valid(out_valid), .out_pix(out_pix)
  );

endmodule

// File: rtl/yrc_chk.sv
module yrc_chk #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [3:0]         reg_be,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [3*PIX_W-1:0] out_pix,
  input logic               end_flag,
  input logic               ctl_en,
  input logic               s2_vld
);

  logic clr_w1c, clr_soft;
  assign clr_w1c  = reg_we && (reg_addr == ADDR_W'(1)) && reg_be[0] && reg_wdata[0];
  assign clr_soft = reg_we && (reg_addr == ADDR_W'(0)) && reg_be[0] && reg_wdata[1];

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr_soft) |=> (out_valid && $stable(out_pix)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |-> !in_ready);

  // R7
  out_from_s2_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(s2_vld));

  // R11
  end_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (end_flag && !clr_w1c && !clr_soft) |=> end_flag);

  // R11
  end_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(end_flag) |-> $past(out_valid && out_ready));

endmodule

bind yuv_rgb_conv yrc_chk #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_be(reg_be), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
  .end_flag(end_flag), .ctl_en(ctl_en), .s2_vld(s2_vld)
);

// File: tb/sim_yuv_rgb_conv.sv
`timescale 1ns/1ps
module sim_yuv_rgb_conv;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_pix;
  logic        end_flag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  yuv_rgb_conv u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_u(in_u),
    .in_v(in_v), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .end_flag(end_flag)
  );

  localparam int VID [5] = '{'h4A8, 'h662, 'h191, 'h341, 'h811};
  localparam int FUL [5] = '{'h400, 'h59C, 'h161, 'h2DC, 'h718};

  // {y, u, v, full_range, layout}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {8'd16,  8'd128, 8'd128, 1'b0, 2'd1},
    {8'd235, 8'd128, 8'd128, 1'b0, 2'd2},
    {8'd81,  8'd90,  8'd240, 1'b0, 2'd2},
    {8'd255, 8'd128, 8'd128, 1'b1, 2'd2},
    {8'd0,   8'd128, 8'd128, 1'b1, 2'd0},
    {8'd128, 8'd255, 8'd0,   1'b1, 2'd1},
    {8'd200, 8'd30,  8'd220, 1'b0, 2'd0},
    {8'd50,  8'd200, 8'd60,  1'b1, 2'd3}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sat(input int s);
    int t;
    t = s + 512;
    if (t < 0) return 0;
    t = t / 1024;
    return (t > 255) ? 255 : t;
  endfunction

  function automatic logic [23:0] model(input int y, input int u, input int v,
                                        input bit full, input int fmt);
    int c[5];
    int yy, uu, vv, r, g, b;
    for (int i = 0; i < 5; i++) c[i] = full ? FUL[i] : VID[i];
    yy = full ? y : y - 16;
    uu = u - 128;
    vv = v - 128;
    r = sat(c[0]*yy + c[1]*vv);
    g = sat(c[0]*yy - c[2]*uu - c[3]*vv);
    b = sat(c[0]*yy + c[4]*uu);
    case (fmt)
      0:       return {9'b0, r[7:3], g[7:3], b[7:3]};
      1:       return {8'b0, r[7:3], g[7:2], b[7:3]};
      default: return {r[7:0], g[7:0], b[7:0]};
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d; reg_be = be;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic set_mode(input bit full, input int fmt);
    wr(2, {14'b0, 2'(fmt), 11'b0, full, 1'b0, 3'd6}, 4'b0101);
    for (int i = 0; i < 5; i++) wr(4 + i, 32'(full ? FUL[i] : VID[i]), 4'b0011);
  endtask

  task automatic px(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v,
                    input logic [23:0] exp, input string req);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_y = y; in_u = u; in_v = v;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R7", 32'(out_valid), 32'd1);
    chk(out_pix == exp, req, 32'(out_pix), 32'(exp));
  endtask

  initial begin
    logic [31:0] d;
    logic [23:0] ea, eb, ec;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset state
    chk(out_valid == 1'b0, "R9 reset out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b0, "R9 reset in_ready", 32'(in_ready), 0);
    chk(end_flag == 1'b0, "R11 reset end_flag", 32'(end_flag), 0);
    for (int i = 0; i < 5; i++) begin
      rd(4 + i, d);
      chk(d == 32'(VID[i]), "R3 R13 default coef", d, 32'(VID[i]));
    end
    rd(2, d);
    chk(d == 32'h0001_0006, "R10 format reset", d, 32'h0001_0006);

    wr(0, 32'h1, 4'h1);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic [7:0] y, u, v;
      logic       fl;
      logic [1:0] fm;
      {y, u, v, fl, fm} = VEC[k];
      set_mode(fl, int'(fm));
      px(y, u, v, model(y, u, v, fl, int'(fm)),
         fm == 2'd0 ? "R1 R6" : fm == 2'd1 ? "R1 R5" : "R1 R2 R4");
    end

    // R3: programmed coefficient used for next pixel
    set_mode(1'b1, 2);
    wr(4, 32'h200, 4'hF);
    px(8'd200, 8'd128, 8'd128, 24'h646464, "R3 programmed C0");

    // R8: backpressure
    set_mode(1'b0, 2);
    ea = model(100, 60, 200, 0, 2);
    eb = model(180, 150, 90, 0, 2);
    ec = model(40, 220, 110, 0, 2);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_y = 100; in_u = 60; in_v = 200;
    @(posedge clk); #1;
    in_y = 180; in_u = 150; in_v = 90;
    @(posedge clk); #1;
    in_y = 40; in_u = 220; in_v = 110;
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == 1'b1 && out_pix == ea, "R8 hold", 32'(out_pix), 32'(ea));
      chk(in_ready == 1'b0, "R8 in_ready stalled", 32'(in_ready), 0);
      @(posedge clk); #1;
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b1 && out_pix == eb, "R8 order B", 32'(out_pix), 32'(eb));
    @(posedge clk); #1;
    chk(out_valid == 1'b1 && out_pix == ec, "R8 order C", 32'(out_pix), 32'(ec));
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R8 drained", 32'(out_valid), 0);

    // R10: byte strobes keep the other field
    wr(2, 32'h0003_0005, 4'b0001);
    rd(2, d);
    chk(d == 32'h0002_0005, "R10 low byte only", d, 32'h0002_0005);
    wr(2, 32'h0000_0007, 4'b0100);
    rd(2, d);
    chk(d == 32'h0000_0005, "R10 layout byte only", d, 32'h0000_0005);

    // R11: end flag
    wr(2, 32'h0002_0006, 4'b0101);
    wr(3, 32'd3, 4'hF);
    px(8'd50, 8'd128, 8'd128, model(50, 128, 128, 0, 2), "R11 pixel 1");
    px(8'd60, 8'd128, 8'd128, model(60, 128, 128, 0, 2), "R11 pixel 2");
    chk(end_flag == 1'b0, "R11 not yet", 32'(end_flag), 0);
    px(8'd70, 8'd128, 8'd128, model(70, 128, 128, 0, 2), "R11 pixel 3");
    chk(end_flag == 1'b0, "R11 before handshake", 32'(end_flag), 0);
    @(posedge clk); #1;
    chk(end_flag == 1'b1, "R11 set", 32'(end_flag), 1);
    repeat (3) @(posedge clk);
    #1;
    rd(1, d);
    chk(d[0] == 1'b1, "R11 sticky", d, 1);
    wr(1, 32'h1, 4'h1);
    chk(end_flag == 1'b0, "R11 cleared", 32'(end_flag), 0);

    // R12: soft clear
    wr(3, 32'd1, 4'hF);
    px(8'd90, 8'd128, 8'd128, model(90, 128, 128, 0, 2), "R12 prime");
    @(posedge clk); #1;
    chk(end_flag == 1'b1, "R12 flag primed", 32'(end_flag), 1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_y = 120; in_u = 128; in_v = 128;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b1, "R12 stalled pixel", 32'(out_valid), 1);
    wr(0, 32'h3, 4'h1);
    chk(out_valid == 1'b0, "R12 pipeline emptied", 32'(out_valid), 0);
    chk(end_flag == 1'b0, "R12 flag cleared", 32'(end_flag), 0);
    out_ready = 1'b1;
    rd(4, d);
    chk(d == 32'(VID[0]), "R12 coef kept", d, 32'(VID[0]));

    // R9: disabled block ignores input
    wr(0, 32'h0, 4'h1);
    @(negedge clk);
    in_valid = 1'b1; in_y = 200;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(in_ready == 1'b0 && out_valid == 1'b0, "R9 disabled",
          {in_ready, out_valid}, 0);
    end
    in_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule